// File: doc/BRIEF.md
# Interrupt Priority Mask Selector

This block holds a set of sixteen latched interrupt requests and, on every cycle, names the one request that may be taken now. Each source has a fixed rank. Before the ranks are compared, each source's eligibility is decided from the machine-state bits, the partition control bits and a few straps. Some sources can never be masked. Some need a partition enable. The external source can get past the external-enable bit when the hypervisor and partition settings route it to the hypervisor. The lower-ranked timer, doorbell and monitor sources need asynchronous delivery to be allowed.

Requests arrive as one-cycle pulses on a request vector and are held in a pending register. The pick is combinational from the pending register and the current state inputs. When the core takes the interrupt, it raises an acknowledge, and on the next clock edge the pending bit of the source shown at that moment is cleared. Fetching the vector, saving state and deasserting the source at its origin are left to the surrounding logic.

Top module: `irq_prio_mask_sel`

## Requirements
- R1: Among the eligible sources, the one with the lowest index is selected. The index is shown on `irq_idx_o` with this ranking, highest priority first: 0 reset, 1 machine check, 2 hypervisor decrementer, 3 hypervisor virtualization, 4 external, 5 critical external, 6 watchdog, 7 critical doorbell, 8 fixed-interval timer, 9 programmable-interval timer, 10 decrementer, 11 doorbell, 12 hypervisor doorbell, 13 performance monitor, 14 thermal, 15 event-based branch. The request bit of each source has the same position in `req_i`.
- R2: Sources 0 and 1 are eligible whenever they are pending, whatever the state and control inputs are.
- R3: Asynchronous delivery is allowed when `msr_ext_en_i` is 1 or `wake_resume_i` is 1.
- R4: Source 2 is eligible only when `hdec_irq_en_i` is 1 and either asynchronous delivery is allowed or `msr_hyp_i` is 0. Source 3 follows the same rule, using `hvirt_irq_en_i` in place of `hdec_irq_en_i`.
- R5: Source 4 is eligible when either of two conditions holds:
  - asynchronous delivery is allowed and not all three of these hold: `hyp_ext_block_i`=1, `msr_hyp_i`=1, `msr_prob_i`=0;
  - `hyp_strap_i`=1, `msr_hyp_i`=0 and `ext_to_guest_i`=0.
- R6: Source 5 is eligible exactly when `msr_crit_en_i` is 1. Asynchronous delivery plays no part.
- R7: Sources 6 to 14 are eligible only while asynchronous delivery is allowed.
- R8: Source 15 is eligible only when asynchronous delivery is allowed, `msr_prob_i` is 1 and `ebb_global_en_i` is 1.
- R9: When no pending source is eligible, `irq_valid_o` is 0 and `irq_idx_o` is 0.
- R10: A 1 on bit i of `req_i` at a clock edge sets pending bit i. The bit stays set until it is acknowledged or reset.
- R11: With `irq_valid_o`=1, `ack_i`=1 at a clock edge clears the pending bit of the source shown on `irq_idx_o`, unless `req_i` sets that same bit in that cycle. While `irq_valid_o`=0, `ack_i` has no effect.
- R12: A clock edge with `rst_n`=0 clears every pending bit, so `irq_valid_o` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 16 | Request pulses, one bit per source |
| ack_i | input | 1 | Take the currently selected interrupt |
| msr_ext_en_i | input | 1 | External-enable state bit |
| msr_crit_en_i | input | 1 | Critical-enable state bit |
| msr_hyp_i | input | 1 | Hypervisor state bit |
| msr_prob_i | input | 1 | Problem (user) state bit |
| wake_resume_i | input | 1 | Resuming from a power-saving state |
| hyp_strap_i | input | 1 | Core implements hypervisor mode |
| hdec_irq_en_i | input | 1 | Hypervisor decrementer enable |
| hvirt_irq_en_i | input | 1 | Hypervisor virtualization enable |
| ext_to_guest_i | input | 1 | External interrupts routed to guest |
| hyp_ext_block_i | input | 1 | Block external delivery to hypervisor |
| ebb_global_en_i | input | 1 | Event-based-branch global enable |
| irq_valid_o | output | 1 | An interrupt is selected |
| irq_idx_o | output | 4 | Index of the selected source |

## Verification
The selection is combinational. A change on a state or control input shows on `irq_valid_o`/`irq_idx_o` in the same cycle. A request pulse or an acknowledge acts through the pending register, so its effect appears in the cycle after the clock edge that samples it. The bench drives every input just after a falling edge. It compares the outputs 1 ns later, against a reference model of the pending bits that it advances once per rising edge. Each comparison therefore covers the state changes applied in that cycle, together with the request and acknowledge effects latched at the rising edge just before.

// File: rtl/irq_sel_pkg.sv
// Package: shared sizes, source ranks and state bundles for the interrupt
// priority mask selector. Assumes the rank order is fixed by the source list.
package irq_sel_pkg;

    localparam int NUM_SRC = 16;
    localparam int IDX_W   = $clog2(NUM_SRC);

    // Source ranks: lower value wins.
    typedef enum logic [IDX_W-1:0] {
        SRC_RESET  = 4'd0,
        SRC_MCHK   = 4'd1,
        SRC_HDEC   = 4'd2,
        SRC_HVIRT  = 4'd3,
        SRC_EXT    = 4'd4,
        SRC_CRIT   = 4'd5,
        SRC_WDOG   = 4'd6,
        SRC_CDBELL = 4'd7,
        SRC_FIT    = 4'd8,
        SRC_PIT    = 4'd9,
        SRC_DEC    = 4'd10,
        SRC_DBELL  = 4'd11,
        SRC_HDBELL = 4'd12,
        SRC_PERF   = 4'd13,
        SRC_THERM  = 4'd14,
        SRC_EBB    = 4'd15
    } src_e;

    // First and last source of the group gated only by asynchronous delivery.
    localparam int ASYNC_FIRST = int'(SRC_WDOG);
    localparam int ASYNC_LAST  = int'(SRC_THERM);

    // Machine-state bits.
    typedef struct packed {
        logic ext_en;
        logic crit_en;
        logic hyp;
        logic prob;
    } mstate_t;

    // Partition control bits and straps.
    typedef struct packed {
        logic hdec_en;
        logic hvirt_en;
        logic ext_to_guest;
        logic hyp_ext_block;
        logic hyp_strap;
        logic ebb_ge;
    } pctl_t;

endpackage

// File: rtl/irq_pend_reg.sv
// Module: pending request register. Set by request pulses and cleared by a
// one-hot clear vector. When a bit is set and cleared in the same cycle, the
// set wins. Assumes synchronous active-low reset.
module irq_pend_reg #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] pend_q;
    logic [N-1:0] pend_d;

    // Next pending value: clear the taken bit, then OR in new requests.
    always_comb begin
        pend_d = (pend_q & ~clr_i) | set_i;
    end

    // Pending storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

    // R12: reset empties the register.
    p_reset_clear_r12: assert property (@(posedge clk) !rst_n |=> (pend_o == '0))
        else $error("pending not cleared by reset");

    // R10: a requested bit is set after the edge.
    p_req_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)))
        else $error("request did not set pending");

    // R10: without clear or reset, no pending bit drops.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((pend_o & $past(pend_o)) == $past(pend_o)))
        else $error("pending bit lost without acknowledge");

endmodule

// File: rtl/irq_gate.sv
// Module: eligibility gating. Turns pending bits into eligible bits from the
// machine state and partition controls. Purely combinational; clk/rst_n are
// used only by the embedded assertions. Assumes source ranks from irq_sel_pkg.
module irq_gate
    import irq_sel_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend_i,
    input  mstate_t      mst_i,
    input  pctl_t        pctl_i,
    input  logic         resume_i,
    output logic [N-1:0] elig_o
);

    logic async_ok;
    logic hv_timer_path;
    logic ext_async_path;
    logic ext_hyp_path;

    // Asynchronous-delivery term.
    always_comb begin
        async_ok = mst_i.ext_en | resume_i;
    end

    // Shared permission for the two hypervisor-level sources.
    always_comb begin
        hv_timer_path = async_ok | ~mst_i.hyp;
    end

    // The two routes by which the external source may be taken.
    always_comb begin
        ext_async_path = async_ok & ~(pctl_i.hyp_ext_block & mst_i.hyp & ~mst_i.prob);
        ext_hyp_path   = pctl_i.hyp_strap & ~mst_i.hyp & ~pctl_i.ext_to_guest;
    end

    // Per-source gating, chosen by source rank.
    for (genvar g = 0; g < N; g++) begin : g_src
        if (g == int'(SRC_RESET) || g == int'(SRC_MCHK)) begin : g_unmask
            assign elig_o[g] = pend_i[g];
        end else if (g == int'(SRC_HDEC)) begin : g_hdec
            assign elig_o[g] = pend_i[g] & pctl_i.hdec_en & hv_timer_path;
        end else if (g == int'(SRC_HVIRT)) begin : g_hvirt
            assign elig_o[g] = pend_i[g] & pctl_i.hvirt_en & hv_timer_path;
        end else if (g == int'(SRC_EXT)) begin : g_ext
            assign elig_o[g] = pend_i[g] & (ext_async_path | ext_hyp_path);
        end else if (g == int'(SRC_CRIT)) begin : g_crit
            assign elig_o[g] = pend_i[g] & mst_i.crit_en;
        end else if (g >= ASYNC_FIRST && g <= ASYNC_LAST) begin : g_async
            assign elig_o[g] = pend_i[g] & async_ok;
        end else begin : g_ebb
            assign elig_o[g] = pend_i[g] & async_ok & mst_i.prob & pctl_i.ebb_ge;
        end
    end

    // R7: without async delivery, no source of the timer/doorbell group is eligible.
    p_async_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mst_i.ext_en && !resume_i) |-> (elig_o[ASYNC_LAST:ASYNC_FIRST] == '0))
        else $error("async group eligible without delivery");

    // R2: unmaskable sources follow their pending bits.
    p_unmask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_o[1:0] == pend_i[1:0]))
        else $error("unmaskable source gated");

endmodule

// File: rtl/irq_prio_enc.sv
// Module: fixed-priority encoder. The lowest set bit wins. Gives valid, a
// binary index and a one-hot grant. Assumes N is a power of two.
module irq_prio_enc #(
    parameter int N = 16,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req_i,
    output logic         valid_o,
    output logic [W-1:0] idx_o,
    output logic [N-1:0] grant_o
);

    logic [N:0] lower_any;

    assign lower_any[0] = 1'b0;

    // Prefix-OR chain: grant bit i only if no lower bit requests.
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign lower_any[i+1] = lower_any[i] | req_i[i];
        assign grant_o[i]     = req_i[i] & ~lower_any[i];
    end

    assign valid_o = lower_any[N];

    // Binary encode of the one-hot grant; zero when nothing is granted.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_o[i]) idx_o = idx_o | W'(i);
        end
    end

endmodule

// File: rtl/irq_prio_mask_sel.sv
// Module: interrupt priority mask selector, top level. Latches request pulses,
// gates each pending source by state and controls, and shows the winning
// source. An acknowledge clears the shown source on the next edge. Assumes
// a synchronous active-low reset and a single clock.
module irq_prio_mask_sel
    import irq_sel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               ack_i,
    input  logic               msr_ext_en_i,
    input  logic               msr_crit_en_i,
    input  logic               msr_hyp_i,
    input  logic               msr_prob_i,
    input  logic               wake_resume_i,
    input  logic               hyp_strap_i,
    input  logic               hdec_irq_en_i,
    input  logic               hvirt_irq_en_i,
    input  logic               ext_to_guest_i,
    input  logic               hyp_ext_block_i,
    input  logic               ebb_global_en_i,
    output logic               irq_valid_o,
    output logic [IDX_W-1:0]   irq_idx_o
);

    mstate_t            mst;
    pctl_t              pctl;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] grant;
    logic [NUM_SRC-1:0] clr;

    // Bundle the state and control pins.
    always_comb begin
        mst.ext_en          = msr_ext_en_i;
        mst.crit_en         = msr_crit_en_i;
        mst.hyp             = msr_hyp_i;
        mst.prob            = msr_prob_i;
        pctl.hdec_en        = hdec_irq_en_i;
        pctl.hvirt_en       = hvirt_irq_en_i;
        pctl.ext_to_guest   = ext_to_guest_i;
        pctl.hyp_ext_block  = hyp_ext_block_i;
        pctl.hyp_strap      = hyp_strap_i;
        pctl.ebb_ge         = ebb_global_en_i;
    end

    // Acknowledge clears exactly the granted source.
    always_comb begin
        clr = ack_i ? grant : '0;
    end

    irq_pend_reg #(.N(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (req_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    irq_gate #(.N(NUM_SRC)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (pend),
        .mst_i    (mst),
        .pctl_i   (pctl),
        .resume_i (wake_resume_i),
        .elig_o   (elig)
    );

    irq_prio_enc #(.N(NUM_SRC)) u_enc (
        .req_i   (elig),
        .valid_o (irq_valid_o),
        .idx_o   (irq_idx_o),
        .grant_o (grant)
    );

    // R2: a pending reset always wins.
    p_reset_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pend[0] |-> (irq_valid_o && irq_idx_o == 4'd0))
        else $error("pending reset not selected");

    // R6: critical external shown only with critical enable.
    p_crit_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && irq_idx_o == 4'd5) |-> msr_crit_en_i)
        else $error("critical source shown without enable");

    // R8: event-based branch shown only in problem state with global enable.
    p_ebb_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && irq_idx_o == 4'd15) |-> (msr_prob_i && ebb_global_en_i))
        else $error("event branch shown without its enables");

    // R9: idle output reports index zero.
    p_idle_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid_o |-> (irq_idx_o == 4'd0))
        else $error("index nonzero while idle");

    // R11: acknowledged bit drops unless re-requested.
    p_ack_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_valid_o && !req_i[irq_idx_o]) |=> !pend[$past(irq_idx_o)])
        else $error("acknowledged source still pending");

    // R11: acknowledge while idle changes nothing.
    p_ack_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_valid_o && req_i == '0) |=> $stable(pend))
        else $error("idle acknowledge changed pending");

endmodule

// File: tb/irq_prio_mask_sel_bench.sv
`timescale 1ns/1ps
module irq_prio_mask_sel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_i = '0;
    logic        ack_i = 1'b0;
    logic        ee = 0, ce = 0, hv = 0, pr = 0, res = 0, strap = 0;
    logic        hdice = 0, hvice = 0, lpes = 0, heic = 0, ge = 0;
    logic        irq_valid_o;
    logic [3:0]  irq_idx_o;

    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 0;
    logic [15:0] m_pend = '0;

    always #2 clk = ~clk;

    irq_prio_mask_sel u_irq_prio_mask_sel (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i),
        .msr_ext_en_i(ee), .msr_crit_en_i(ce), .msr_hyp_i(hv), .msr_prob_i(pr),
        .wake_resume_i(res), .hyp_strap_i(strap), .hdec_irq_en_i(hdice),
        .hvirt_irq_en_i(hvice), .ext_to_guest_i(lpes), .hyp_ext_block_i(heic),
        .ebb_global_en_i(ge), .irq_valid_o(irq_valid_o), .irq_idx_o(irq_idx_o)
    );

    // Reference: {valid, idx} from the requirement text.
    function automatic logic [4:0] model(logic [15:0] p);
        logic [15:0] e;
        logic a;
        a = ee | res;
        e = '0;
        e[0] = p[0];
        e[1] = p[1];
        e[2] = p[2] & hdice & (a | ~hv);
        e[3] = p[3] & hvice & (a | ~hv);
        e[4] = p[4] & ((a & ~(heic & hv & ~pr)) | (strap & ~hv & ~lpes));
        e[5] = p[5] & ce;
        for (int i = 6; i <= 14; i++) e[i] = p[i] & a;
        e[15] = p[15] & a & pr & ge;
        for (int i = 0; i < 16; i++) if (e[i]) return {1'b1, 4'(i)};
        return 5'd0;
    endfunction

    task automatic set_state(input logic [10:0] s);
        {ee, ce, hv, pr, res, strap, hdice, hvice, lpes, heic, ge} = s;
    endtask

    // Check outputs (model and optional explicit value), then advance a cycle.
    task automatic step(input string tag, input bit use_exp, input logic ev, input logic [3:0] ei);
        logic [4:0] m;
        logic [15:0] nxt;
        #1;
        m = model(m_pend);
        n_checks++;
        if ({irq_valid_o, irq_idx_o} !== m) begin
            n_errors++;
            $display("FAIL %s: got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
                     tag, irq_valid_o, irq_idx_o, m[4], m[3:0]);
        end
        if (use_exp) begin
            n_checks++;
            if ({irq_valid_o, irq_idx_o} !== {ev, ei}) begin
                n_errors++;
                $display("FAIL %s: got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
                         tag, irq_valid_o, irq_idx_o, ev, ei);
            end
        end
        nxt = m_pend;
        if (ack_i && m[4]) nxt[m[3:0]] = 1'b0;
        nxt = nxt | req_i;
        if (!rst_n) nxt = '0;
        @(negedge clk);
        m_pend = nxt;
        req_i = '0;
        ack_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_i = '1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        req_i = '0;
        m_pend = '0;
    endtask

    initial begin : wdog
        #(200000 * 4);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd4242);
        @(negedge clk);
        do_reset();
        // R12: reset state, even with all requests raised during reset
        set_state(11'b0);
        step("R12 reset", 1, 1'b0, 4'd0);

        // R8/R10: event-branch request with all enables
        set_state({1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1});
        req_i[15] = 1'b1;
        step("R10 latch", 0, 1'b0, 4'd0);
        step("R8 ebb on", 1, 1'b1, 4'd15);
        ge = 0;
        step("R8 no global enable", 1, 1'b0, 4'd0);
        ge = 1; ee = 0; res = 1;
        step("R3 resume path", 1, 1'b1, 4'd15);
        res = 0;
        step("R9 no async", 1, 1'b0, 4'd0);

        // R1/R7: decrementer outranks event branch
        ee = 1; req_i[10] = 1'b1;
        step("R10 latch dec", 0, 1'b1, 4'd15);
        step("R1 dec over ebb", 1, 1'b1, 4'd10);
        ee = 0;
        step("R7 dec masked", 1, 1'b0, 4'd0);

        // R6: critical external ignores async term
        ce = 1; req_i[5] = 1'b1;
        step("R10 latch crit", 0, 1'b0, 4'd0);
        step("R6 crit no ee", 1, 1'b1, 4'd5);
        ce = 0; ee = 1;
        step("R6 crit disabled", 1, 1'b1, 4'd10);

        // R11: acknowledge clears crit, then dec shows
        ce = 1; ack_i = 1;
        step("R11 ack crit", 1, 1'b1, 4'd5);
        step("R11 after ack", 1, 1'b1, 4'd10);
        ee = 0; ce = 0; ack_i = 1;
        step("R11 idle ack", 1, 1'b0, 4'd0);
        ee = 1;
        step("R11 idle ack no effect", 1, 1'b1, 4'd10);
        ack_i = 1; req_i[10] = 1'b1;
        step("R11 ack with req", 1, 1'b1, 4'd10);
        step("R11 req wins", 1, 1'b1, 4'd10);

        // R4: hypervisor decrementer
        req_i[2] = 1'b1;
        step("R10 latch hdec", 0, 1'b1, 4'd10);
        step("R4 hdec disabled", 1, 1'b1, 4'd10);
        hdice = 1;
        step("R4 hdec on", 1, 1'b1, 4'd2);
        ee = 0; hv = 1;
        step("R4 hdec hv no async", 1, 1'b0, 4'd0);
        hv = 0;
        step("R4 hdec guest", 1, 1'b1, 4'd2);

        // R2: unmaskable sources
        do_reset();
        set_state(11'b0);
        req_i[1] = 1'b1;
        step("R10 latch mchk", 0, 1'b0, 4'd0);
        step("R2 mchk", 1, 1'b1, 4'd1);
        req_i[0] = 1'b1;
        step("R10 latch rst", 0, 1'b1, 4'd1);
        step("R2 reset wins", 1, 1'b1, 4'd0);

        // R5: external routes
        do_reset();
        set_state(11'b0);
        ee = 1; heic = 1; hv = 1; pr = 0;
        req_i[4] = 1'b1;
        step("R10 latch ext", 0, 1'b0, 4'd0);
        step("R5 hyp block", 1, 1'b0, 4'd0);
        pr = 1;
        step("R5 problem state", 1, 1'b1, 4'd4);
        ee = 0; heic = 0; hv = 0; pr = 0; strap = 1; lpes = 0;
        step("R5 hyp route", 1, 1'b1, 4'd4);
        lpes = 1;
        step("R5 guest route", 1, 1'b0, 4'd0);
        // R4: hypervisor virtualization in guest state
        hvice = 1; req_i[3] = 1'b1;
        step("R10 latch hvirt", 0, 1'b0, 4'd0);
        step("R4 hvirt guest", 1, 1'b1, 4'd3);

        // R1: random mix
        for (int k = 0; k < 4000; k++) begin
            if (k % 500 == 0) do_reset();
            set_state(11'($urandom));
            req_i = 16'($urandom & $urandom & $urandom);
            ack_i = 1'($urandom);
            step("R1 random", 0, 1'b0, 4'd0);
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule